// File: doc/BRIEF.md
# TDM Slot Receiver with Frame-Sync Checking

This block receives a time-division-multiplexed serial audio stream as a slave. An external master supplies the bit clock and a frame-sync pulse. The block samples the frame sync and the serial data on every rising bit-clock edge. It cuts each frame into three slots of 32 bit clocks each. From each slot it keeps the 10-bit field at the start of the slot and discards the rest. Each finished word is presented with its slot number and a one-cycle valid strobe.

The receiver also checks where each frame sync falls. A sync that arrives before the current frame is complete is an early error. The block keeps the slots it has already completed, drops the whole frame that the early sync opens, and delivers again from the following frame. When no sync is present right after the last bit of a frame, the block flags a late error. It ignores the gap bits and realigns on the next sync that arrives. Both cases set one sticky error flag, which a one-cycle clear input resets. A pulse output marks each event and carries a bit that tells early from late.

A programmable offset of 0, 1 or 2 bit clocks separates the frame sync from the first data bit. All sync checking uses this offset.

Top module: `tdm_sync_rx`

## Requirements
- R1: After reset, all outputs are low and the receiver is unsynchronised. Data received before the first frame sync produces no word, and the first sync raises no error.
- R2: A frame is 3 slots of 32 bits each. `word_data` holds the first 10 bits received in the slot, with the first bit in bit 9 (the MSB). The other 22 bits of the slot do not affect any output.
- R3: `word_valid` is high for exactly one cycle, the cycle after the last bit of a slot is sampled. `word_slot` gives the slot number: 0, 1 and 2 in order through the frame.
- R4: A sync event is a cycle in which `fs` is sampled high after being sampled low in the previous cycle. The first data bit is sampled `dly` cycles after the sync event (0 = the same cycle). A `dly` value of 3 behaves like 2.
- R5: If a sync event's first-data cycle comes before the last bit of the current frame, this is an early error. `err_pulse` goes high on the next cycle with `err_late`=0. Slots completed before the error were already delivered. The frame opened by that sync delivers no word.
- R6: After an early error, a sync whose first-data cycle comes right after the last bit of the dropped frame raises no error, and that frame is delivered in full.
- R7: If the cycle after the last bit of a frame has no aligned sync, this is a late error. `err_pulse` goes high on the next cycle with `err_late`=1. The gap bits are ignored, and the next sync realigns the receiver without a further error, with its frame delivered.
- R8: `err_flag` sets on every error and holds until `err_clr` is sampled high. If a clear and an error fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the external master |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | 1 | Frame sync from the master |
| sd | input | 1 | Serial data |
| dly | input | 2 | Bit clocks from sync to first data bit (0..2, 3 acts as 2) |
| err_clr | input | 1 | One-cycle clear of the sticky error flag |
| word_valid | output | 1 | One-cycle strobe for a delivered word |
| word_data | output | 10 | Left-aligned data field of the slot |
| word_slot | output | 2 | Slot number of the delivered word |
| err_flag | output | 1 | Sticky sync-error flag |
| err_pulse | output | 1 | One-cycle pulse for each sync error |
| err_late | output | 1 | With err_pulse: 1 = late error, 0 = early error |

## Verification
A clear of the sticky flag can land in the same cycle as a newly detected sync error. The bench holds `err_clr` high across a whole early-sync frame boundary, so the clear is present in the cycle where the error is detected. The bench then requires that `err_flag` reads high while the clear is still applied, and that it falls only one cycle later. A second collision happens inside the data path, where the word of the last complete slot and the early error come out close together. The per-cycle reference model judges it by comparing every output on every clock.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int SLOTS_DEF     = 3;
    localparam int SLOT_BITS_DEF = 32;
    localparam int DATA_BITS_DEF = 10;
    localparam int MAX_DLY       = 2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic hit;
        logic late;
    } sync_err_t;

    function automatic logic [1:0] clamp_dly(input logic [1:0] d);
        return (d > 2'(MAX_DLY)) ? 2'(MAX_DLY) : d;
    endfunction

endpackage

// File: rtl/tdm_sync_align.sv
module tdm_sync_align
    import tdm_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fs,
    input  logic [1:0] dly,
    output logic       sync_aligned
);
    logic                 fs_q;
    logic                 edge_now;
    logic [MAX_DLY:0]     taps;
    logic [MAX_DLY:1]     edge_dly;

    always_ff @(posedge clk) begin
        if (rst) fs_q <= 1'b0;
        else     fs_q <= fs;
    end

    assign edge_now = fs & ~fs_q;

    generate
        for (genvar g = 1; g <= MAX_DLY; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) edge_dly[g] <= 1'b0;
                else if (g == 1) edge_dly[g] <= edge_now;
                else edge_dly[g] <= taps[g-1];
            end
        end
    endgenerate

    always_comb begin
        taps[0] = edge_now;
        for (int i = 1; i <= MAX_DLY; i++) taps[i] = edge_dly[i];
    end

    assign sync_aligned = taps[clamp_dly(dly)];
endmodule

// File: rtl/tdm_frame_track.sv
module tdm_frame_track
    import tdm_rx_pkg::*;
#(
    parameter int SLOTS     = SLOTS_DEF,
    parameter int SLOT_BITS = SLOT_BITS_DEF,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_aligned,
    output logic              cap_vld,
    output logic [SLOT_W-1:0] cap_slot,
    output logic [BIT_W-1:0]  cap_bit,
    output sync_err_t         err_evt
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);

    lock_state_e       st_q, st_d;
    logic              skip_q, skip_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic              frame_done;

    assign frame_done = (st_q == ST_LOCK) && (slot_q == SLOT_LAST) && (bit_q == BIT_LAST);

    always_comb begin
        st_d    = st_q;
        skip_d  = skip_q;
        slot_d  = slot_q;
        bit_d   = bit_q;
        err_evt = '0;
        if (sync_aligned) begin
            err_evt.hit = (st_q == ST_LOCK) && !frame_done;
            skip_d      = (st_q == ST_LOCK) && !frame_done;
            st_d        = ST_LOCK;
            slot_d      = '0;
            bit_d       = '0;
        end else if (frame_done) begin
            err_evt.hit  = 1'b1;
            err_evt.late = 1'b1;
            st_d         = ST_HUNT;
        end else if (st_q == ST_LOCK) begin
            if (bit_q == BIT_LAST) begin
                bit_d  = '0;
                slot_d = slot_q + 1'b1;
            end else begin
                bit_d = bit_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            skip_q <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
        end else begin
            st_q   <= st_d;
            skip_q <= skip_d;
            slot_q <= slot_d;
            bit_q  <= bit_d;
        end
    end

    assign cap_vld  = (st_d == ST_LOCK) && !skip_d;
    assign cap_slot = slot_d;
    assign cap_bit  = bit_d;
endmodule

// File: rtl/tdm_slot_pack.sv
module tdm_slot_pack #(
    parameter int SLOTS     = 3,
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 10,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sd,
    input  logic                 cap_vld,
    input  logic [SLOT_W-1:0]    cap_slot,
    input  logic [BIT_W-1:0]     cap_bit,
    output logic                 word_valid,
    output logic [DATA_BITS-1:0] word_data,
    output logic [SLOT_W-1:0]    word_slot
);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(SLOT_BITS - 1);
    localparam logic [BIT_W-1:0] DATA_SPAN = BIT_W'(DATA_BITS);

    logic [DATA_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_slot  <= '0;
        end else begin
            if (cap_vld && cap_bit < DATA_SPAN)
                shreg <= {shreg[DATA_BITS-2:0], sd};
            word_valid <= cap_vld && (cap_bit == BIT_LAST);
            if (cap_vld && cap_bit == BIT_LAST) begin
                word_data <= shreg;
                word_slot <= cap_slot;
            end
        end
    end
endmodule

// File: rtl/tdm_sync_rx.sv
module tdm_sync_rx
    import tdm_rx_pkg::*;
#(
    parameter int SLOTS     = SLOTS_DEF,
    parameter int SLOT_BITS = SLOT_BITS_DEF,
    parameter int DATA_BITS = DATA_BITS_DEF,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fs,
    input  logic                 sd,
    input  logic [1:0]           dly,
    input  logic                 err_clr,
    output logic                 word_valid,
    output logic [DATA_BITS-1:0] word_data,
    output logic [SLOT_W-1:0]    word_slot,
    output logic                 err_flag,
    output logic                 err_pulse,
    output logic                 err_late
);
    logic              sync_aligned;
    logic              cap_vld;
    logic [SLOT_W-1:0] cap_slot;
    logic [BIT_W-1:0]  cap_bit;
    sync_err_t         err_evt;

    tdm_sync_align u_align (
        .clk          (clk),
        .rst          (rst),
        .fs           (fs),
        .dly          (dly),
        .sync_aligned (sync_aligned)
    );

    tdm_frame_track #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_track (
        .clk          (clk),
        .rst          (rst),
        .sync_aligned (sync_aligned),
        .cap_vld      (cap_vld),
        .cap_slot     (cap_slot),
        .cap_bit      (cap_bit),
        .err_evt      (err_evt)
    );

    tdm_slot_pack #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .sd         (sd),
        .cap_vld    (cap_vld),
        .cap_slot   (cap_slot),
        .cap_bit    (cap_bit),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_slot  (word_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag  <= 1'b0;
            err_pulse <= 1'b0;
            err_late  <= 1'b0;
        end else begin
            err_pulse <= err_evt.hit;
            err_late  <= err_evt.hit && err_evt.late;
            if (err_evt.hit)  err_flag <= 1'b1;
            else if (err_clr) err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_sync_rx_chk.sv
module tdm_sync_rx_chk #(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              err_clr,
    input logic              word_valid,
    input logic [SLOT_W-1:0] word_slot,
    input logic              err_flag,
    input logic              err_pulse,
    input logic              err_late
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!word_valid && !err_flag && !err_pulse));

    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    a_r3_slot_range: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (int'(word_slot) < SLOTS));

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    a_r7_late_with_pulse: assert property (@(posedge clk) disable iff (rst)
        err_late |-> err_pulse);

    a_r8_flag_rises_on_error: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> err_pulse);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    a_r8_error_beats_clear: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_flag);
endmodule

bind tdm_sync_rx tdm_sync_rx_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .err_clr    (err_clr),
    .word_valid (word_valid),
    .word_slot  (word_slot),
    .err_flag   (err_flag),
    .err_pulse  (err_pulse),
    .err_late   (err_late)
);

// File: tb/tb_tdm_sync_rx.sv
`timescale 1ns/1ps
module tb_tdm_sync_rx;
    localparam int NSLOT = 3;
    localparam int SBITS = 32;
    localparam int DBITS = 10;
    localparam int FBITS = NSLOT * SBITS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fs = 1'b0;
    logic       sd = 1'b0;
    logic [1:0] dly = 2'd0;
    logic       err_clr = 1'b0;
    logic             word_valid;
    logic [DBITS-1:0] word_data;
    logic [1:0]       word_slot;
    logic             err_flag, err_pulse, err_late;

    tdm_sync_rx dut (
        .clk(clk), .rst(rst), .fs(fs), .sd(sd), .dly(dly), .err_clr(err_clr),
        .word_valid(word_valid), .word_data(word_data), .word_slot(word_slot),
        .err_flag(err_flag), .err_pulse(err_pulse), .err_late(err_late)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int    cyc = 0;
    bit    fs_prev = 0;
    int    aq[$];
    int    bq[$];
    bit    locked = 0, skip = 0;
    int    pos = 0;
    bit    exp_valid = 0, exp_pulse = 0, exp_late = 0, exp_flag = 0;
    int    exp_data = 0, exp_slot = 0;
    bit    started = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            cyc = 0; fs_prev = 0; aq.delete(); bq.delete();
            locked = 0; skip = 0; pos = 0;
            exp_valid = 0; exp_pulse = 0; exp_late = 0; exp_flag = 0;
        end else begin
            int  d;
            bit  ev, e_err, e_late, nv;
            cyc++;
            d = (dly == 2'd3) ? 2 : int'(dly);
            if (fs && !fs_prev) aq.push_back(cyc + d);
            fs_prev = fs;
            ev = 0;
            if (aq.size() > 0 && aq[0] == cyc) begin ev = 1; void'(aq.pop_front()); end
            e_err = 0; e_late = 0; nv = 0;
            if (ev) begin
                if (locked && pos != FBITS - 1) begin e_err = 1; skip = 1; end
                else skip = 0;
                locked = 1; pos = 0; bq.delete();
            end else if (locked) begin
                if (pos == FBITS - 1) begin e_err = 1; e_late = 1; locked = 0; end
                else pos++;
            end
            if (locked && !skip) begin
                bq.push_back(int'(sd));
                if (pos % SBITS == SBITS - 1) begin
                    nv = 1; exp_data = 0;
                    for (int k = 0; k < DBITS; k++) exp_data = exp_data * 2 + bq[k];
                    exp_slot = pos / SBITS;
                    bq.delete();
                end
            end
            exp_valid = nv; exp_pulse = e_err; exp_late = e_late;
            if (e_err) exp_flag = 1;
            else if (err_clr) exp_flag = 0;
        end
    end

    int n_words = 0, n_early = 0, n_late = 0, n_flag_clr = 0;

    always @(negedge clk) begin
        if (started) begin
            chk(word_valid === exp_valid, "R3 word_valid", int'(word_valid), int'(exp_valid));
            if (exp_valid) begin
                chk(int'(word_data) == exp_data, "R2 word_data", int'(word_data), exp_data);
                chk(int'(word_slot) == exp_slot, "R3 word_slot", int'(word_slot), exp_slot);
            end
            chk(err_pulse === exp_pulse, "R5 R7 err_pulse", int'(err_pulse), int'(exp_pulse));
            if (exp_pulse)
                chk(err_late === exp_late, "R5 R7 err_late", int'(err_late), int'(exp_late));
            chk(err_flag === exp_flag, "R8 err_flag", int'(err_flag), int'(exp_flag));
            if (word_valid) n_words++;
            if (err_pulse && !err_late) n_early++;
            if (err_pulse && err_late) n_late++;
            if (err_clr && err_flag) n_flag_clr++;
        end
    end

    task automatic do_reset(input logic [1:0] d);
        @(negedge clk);
        rst = 1; fs = 0; err_clr = 0; dly = d;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic frame(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            fs = (i == 0);
            sd = 1'($urandom % 2);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fs = 0;
            sd = 1'($urandom % 2);
        end
    endtask

    initial begin
        int w0, e0, l0;
        // R1: reset state and nothing before the first sync
        do_reset(2'd0);
        @(negedge clk);
        chk(!word_valid && !err_flag && !err_pulse, "R1 reset outputs", int'(word_valid | err_flag | err_pulse), 0);
        w0 = n_words; e0 = n_early; l0 = n_late;
        idle(40);
        chk(n_words == w0, "R1 no words before sync", n_words - w0, 0);
        frame(FBITS); frame(FBITS); idle(200);
        chk(n_words - w0 == 6, "R1 two frames delivered", n_words - w0, 6);
        chk(n_early == e0, "R1 first sync no error", n_early - e0, 0);
        chk(n_late - l0 == 1, "R7 trailing late error", n_late - l0, 1);

        // R4 R5 R6: early sync under each offset setting
        for (int d = 0; d < 4; d++) begin
            do_reset(2'(d));
            w0 = n_words; e0 = n_early; l0 = n_late;
            frame(FBITS); frame(50); frame(FBITS); frame(FBITS); idle(200);
            chk(n_words - w0 == 7, "R4 R5 R6 words with early sync", n_words - w0, 7);
            chk(n_early - e0 == 1, "R5 early count", n_early - e0, 1);
            chk(n_late - l0 == 1, "R6 no extra error after resync", n_late - l0, 1);
        end

        // R7: late sync with a four-bit gap
        do_reset(2'd1);
        w0 = n_words; e0 = n_early; l0 = n_late;
        frame(FBITS); frame(FBITS + 4); frame(FBITS); frame(FBITS); idle(200);
        chk(n_words - w0 == 12, "R7 words with late gap", n_words - w0, 12);
        chk(n_late - l0 == 2, "R7 late count", n_late - l0, 2);
        chk(n_early == e0, "R7 no early error", n_early - e0, 0);

        // R8: clear held across an early error, then sticky and clear
        do_reset(2'd0);
        n_flag_clr = 0;
        frame(FBITS);
        @(negedge clk); err_clr = 1;
        fs = 1; sd = 0;
        frame(49);
        frame(FBITS);
        err_clr = 0;
        chk(n_flag_clr > 0, "R8 error wins over clear", n_flag_clr, 1);
        chk(!err_flag, "R8 clear after collision", int'(err_flag), 0);
        frame(FBITS); idle(150);
        chk(err_flag === 1'b1, "R8 flag sticky", int'(err_flag), 1);
        err_clr = 1;
        @(negedge clk); err_clr = 0;
        @(negedge clk);
        chk(err_flag === 1'b0, "R8 flag cleared", int'(err_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule